// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register accesses to an external transceiver over a two-wire management bus. A host strobes one request carrying an operation flag, a 5-bit PHY address, a register address and 16 bits of write data. The block then builds the serial frame, drives it on the data line, and produces the management clock from the system clock. Each clock period of that bus is `2*HALF_CYC` system clocks. When the access completes, the block pulses `done`, and for a read it presents the returned value on `rd_data`.

Every access starts with a run of logic ones. A read then sends a 16-bit command and releases the line. It samples a fixed window of 19 bus periods, which covers the turnaround, the 16 data bits and one trailing idle bit, and aligns the result afterwards. A write sends a 32-bit frame and then gives two more periods with the line released. If a register address does not fit in five bits, the block refuses the request without touching the bus. A refused read returns all ones.

The control is one state machine with these states:
- `ST_IDLE`: waits for a request.
- `ST_PREAMBLE`: drives the run of ones.
- `ST_COMMAND`: shifts out the command or frame.
- `ST_CAPTURE`: the read sample window.
- `ST_RELEASE`: the write tail.
- `ST_FINISH`: the done cycle of a bus access.
- `ST_REJECT`: the done cycle of a refused request.

The transitions are:
- `ST_IDLE` goes to `ST_PREAMBLE` on a valid address, or to `ST_REJECT` on an address above 31.
- `ST_PREAMBLE` goes to `ST_COMMAND` after `PRE_BITS` periods.
- `ST_COMMAND` goes to `ST_CAPTURE` after 16 periods for a read, or to `ST_RELEASE` after 32 periods for a write.
- `ST_CAPTURE` goes to `ST_FINISH` after 19 periods.
- `ST_RELEASE` goes to `ST_FINISH` after 2 periods.
- `ST_FINISH` and `ST_REJECT` return to `ST_IDLE`.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever idle, `mdc` is low and `mdio_oe`, `busy` and `done` are low.
- R2: Every bus access begins with `PRE_BITS` (default 32) periods in which `mdio_oe` is high and `mdio_o` is 1 at each rising edge of `mdc`.
- R3: After the preamble, a read drives 16 bits MSB first, sampled at `mdc` rising edges: `11`, `01`, `10`, PHY address[4:0], register address[4:0].
- R4: After the read command, `mdio_oe` is low for exactly 19 `mdc` periods. `mdio_i` is sampled once per period into a 19-bit value, first sample at the MSB. `rd_data` equals that value shifted right by one and masked to 16 bits, and it is valid in the cycle `done` is high.
- R5: After the preamble, a write drives 32 bits MSB first: `01`, `01`, PHY address, register address, `10`, then write data[15:0].
- R6: After the write frame, the block gives exactly two more `mdc` periods with `mdio_oe` low and then finishes.
- R7: `mdc` is high for exactly `HALF_CYC` system clocks and has a period of `2*HALF_CYC` clocks. `mdio_o` and `mdio_oe` change only while `mdc` is low. The default `HALF_CYC` = 50 gives 2.5 MHz from a 250 MHz clock.
- R8: A request whose register address exceeds 31 causes no `mdc` edge and no `mdio_oe`. `done` pulses on the cycle after the strobe. For a read, `rd_data` is 0xFFFF at that pulse. A refused write leaves `rd_data` unchanged.
- R9: `busy` rises on the cycle after an accepted strobe and stays high until the `done` cycle. Strobes while `busy` is high are ignored.
- R10: `done` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_IN_W | Register address; values above 31 are refused |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with `HALF_CYC` = 3, `PRE_BITS` = 32 and `REG_IN_W` = 6. With these values a whole read of 67 bus periods fits in roughly 400 system clocks, so several full reads, writes, refused requests and an ignored mid-access strobe all run in one short simulation. The 6-bit register input makes addresses 32 to 63 reachable, which exercises the refusal path. The odd, small half period still separates the high and low phases clearly enough to check the exact `mdc` period and that data stays stable while `mdc` is high.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_COMMAND,
        ST_CAPTURE,
        ST_RELEASE,
        ST_FINISH,
        ST_REJECT
    } mdio_state_t;

    localparam int RD_CMD_BITS  = 16;
    localparam int WR_CMD_BITS  = 32;
    localparam int RD_WIN_BITS  = 19;
    localparam int WR_TAIL_BITS = 2;
    localparam int FRAME_W      = 32;

    // Frame left-aligned in 32 bits; a read uses only the upper 16.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic        is_write,
        input logic [4:0]  phy,
        input logic [4:0]  regn,
        input logic [15:0] wdata
    );
        if (is_write)
            return {2'b01, 2'b01, phy, regn, 2'b10, wdata};
        else
            return {2'b11, 2'b01, 2'b10, phy, regn, 16'h0000};
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int HALF_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic bit_end_stb
);
    logic phase_q;
    logic half_end;

    generate
        if (HALF_CYC > 1) begin : g_count
            localparam int CW = $clog2(HALF_CYC);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (!run || half_end)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            assign half_end = run && (cnt_q == CW'(HALF_CYC - 1));
        end else begin : g_direct
            assign half_end = run;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (!run)
            phase_q <= 1'b0;
        else if (half_end)
            phase_q <= ~phase_q;
    end

    assign mdc         = phase_q;
    assign rise_stb    = half_end && !phase_q;
    assign bit_end_stb = half_end && phase_q;

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= load_val;
        else if (shift)
            sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb = sr_q[W-1];

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int WIN = 19
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           sample,
    input  logic           din,
    output logic [WIN-1:0] cap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap <= '0;
        else if (clear)
            cap <= '0;
        else if (sample)
            cap <= {cap[WIN-2:0], din};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int HALF_CYC = 50,
    parameter int PRE_BITS = 32,
    parameter int REG_IN_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [4:0]          req_phy,
    input  logic [REG_IN_W-1:0] req_reg,
    input  logic [15:0]         req_wdata,
    output logic                busy,
    output logic                done,
    output logic [15:0]         rd_data,
    output logic                mdc,
    output logic                mdio_o,
    output logic                mdio_oe,
    input  logic                mdio_i
);
    localparam int MAXB  = (PRE_BITS > FRAME_W) ? PRE_BITS : FRAME_W;
    localparam int CNT_W = $clog2(MAXB);

    mdio_state_t state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic op_wr_q;
    logic run, rise_stb, bit_end_stb, tx_msb;
    logic accept, addr_bad;
    logic [RD_WIN_BITS-1:0] cap;
    logic [15:0] cap_aligned;
    logic unused_edge_bits;

    assign addr_bad = (req_reg > REG_IN_W'(31));
    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign run      = (state_q == ST_PREAMBLE) || (state_q == ST_COMMAND) ||
                      (state_q == ST_CAPTURE)  || (state_q == ST_RELEASE);

    function automatic logic at_last(input logic [CNT_W-1:0] c, input int n);
        return c == CNT_W'(n - 1);
    endfunction

    mdio_clk_gen #(.HALF_CYC(HALF_CYC)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mdc(mdc), .rise_stb(rise_stb), .bit_end_stb(bit_end_stb)
    );

    mdio_tx_shift #(.W(FRAME_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(accept && !addr_bad),
        .load_val(build_frame(req_write, req_phy, req_reg[4:0], req_wdata)),
        .shift(bit_end_stb && (state_q == ST_COMMAND)),
        .msb(tx_msb)
    );

    mdio_rx_capture #(.WIN(RD_WIN_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .clear(accept),
        .sample(rise_stb && (state_q == ST_CAPTURE)),
        .din(mdio_i),
        .cap(cap)
    );

    assign cap_aligned      = cap[16:1];
    assign unused_edge_bits = ^{cap[RD_WIN_BITS-1:17], cap[0]};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (req_valid) state_d = addr_bad ? ST_REJECT : ST_PREAMBLE;
            ST_PREAMBLE:
                if (bit_end_stb && at_last(bit_cnt_q, PRE_BITS)) state_d = ST_COMMAND;
            ST_COMMAND:
                if (bit_end_stb && at_last(bit_cnt_q, op_wr_q ? WR_CMD_BITS : RD_CMD_BITS))
                    state_d = op_wr_q ? ST_RELEASE : ST_CAPTURE;
            ST_CAPTURE:
                if (bit_end_stb && at_last(bit_cnt_q, RD_WIN_BITS)) state_d = ST_FINISH;
            ST_RELEASE:
                if (bit_end_stb && at_last(bit_cnt_q, WR_TAIL_BITS)) state_d = ST_FINISH;
            ST_FINISH, ST_REJECT:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // State register and per-state counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            op_wr_q   <= 1'b0;
            rd_data   <= 16'h0000;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                bit_cnt_q <= '0;
            else if (bit_end_stb)
                bit_cnt_q <= bit_cnt_q + 1'b1;
            if (accept)
                op_wr_q <= req_write;
            if (accept && addr_bad && !req_write)
                rd_data <= 16'hFFFF;
            else if ((state_q == ST_CAPTURE) && (state_d == ST_FINISH))
                rd_data <= cap_aligned;
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH) || (state_q == ST_REJECT);
        mdio_oe = (state_q == ST_PREAMBLE) || (state_q == ST_COMMAND);
        mdio_o  = (state_q == ST_PREAMBLE) ? 1'b1 :
                  (state_q == ST_COMMAND)  ? tx_msb : 1'b0;
    end

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    // R1: an idle block keeps the bus quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R7: line value and enable hold while mdc is high
    a_r7_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R9: a strobe while idle makes the block busy
    a_r9_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8/R6: mdc never toggles in a done cycle
    a_r8_done_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdc);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    localparam int HALF = 3;
    localparam int PRE  = 32;
    localparam int RW   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_phy = '0;
    logic [RW-1:0] req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic mdio_i = 1'b1;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    mdio_master #(.HALF_CYC(HALF), .PRE_BITS(PRE), .REG_IN_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Bus log: {oe, data} at each mdc rising edge
    logic [1:0] blog [0:127];
    int blog_n = 0;
    always @(posedge mdc) begin
        if (blog_n < 128) blog[blog_n] = {mdio_oe, mdio_o};
        blog_n = blog_n + 1;
    end

    // Timing monitor
    int cyc = 0, last_rise = 0, hi_run = 0, timing_bad = 0;
    logic seen_rise = 1'b0, mdc_d = 1'b0, o_d = 1'b0, oe_d = 1'b0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mdc && mdc_d && ((mdio_o != o_d) || (mdio_oe != oe_d))) timing_bad++;
        if (mdc && !mdc_d) begin
            if (seen_rise && (cyc - last_rise != 2*HALF)) timing_bad++;
            last_rise = cyc;
            seen_rise = 1'b1;
        end
        if (mdc) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run != HALF) timing_bad++;
            hi_run = 0;
        end
        mdc_d = mdc; o_d = mdio_o; oe_d = mdio_oe;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic start_req(input logic wr, input logic [4:0] phy, input logic [RW-1:0] rg, input logic [15:0] d);
        @(negedge clk);
        blog_n = 0;
        seen_rise = 1'b0;
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output int waited);
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic check_preamble(input string req);
        int bad = 0;
        for (int i = 0; i < PRE; i++) if (blog[i] != 2'b11) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        check(mdc == 1'b0, "R1 mdc", mdc, 0);
        check(mdio_oe == 1'b0, "R1 oe", mdio_oe, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d, input bit poke);
        logic [18:0] resp;
        logic [15:0] cmd;
        int w, bad;
        resp = {1'b1, 1'b0, d, 1'b1};
        cmd  = {2'b11, 2'b01, 2'b10, phy, rg};
        fork
            begin
                @(negedge mdio_oe);
                for (int i = 18; i >= 0; i--) begin
                    mdio_i = resp[i];
                    @(negedge mdc);
                end
                mdio_i = 1'b1;
            end
        join_none
        start_req(1'b0, phy, {1'b0, rg}, 16'h0);
        check(busy == 1'b1, "R9 busy after strobe", busy, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_reg = 6'd3;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_done(w);
        check(done == 1'b1, "R4 done reached", done, 1);
        check(rd_data == d, "R4 read data", rd_data, d);
        check(blog_n == PRE + 16 + 19, "R4 period count", blog_n, PRE + 35);
        check_preamble("R2 read preamble");
        bad = 0;
        for (int i = 0; i < 16; i++) if (blog[PRE+i] != {1'b1, cmd[15-i]}) bad++;
        check(bad == 0, "R3 command bits", bad, 0);
        bad = 0;
        for (int i = 0; i < 19; i++) if (blog[PRE+16+i][1] != 1'b0) bad++;
        check(bad == 0, "R4 line released", bad, 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done single", done, 0);
        check(busy == 1'b0, "R9 busy clears", busy, 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            check(busy == 1'b0 && blog_n == PRE + 35, "R9 strobe while busy ignored", blog_n, PRE + 35);
        end
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        logic [31:0] fr;
        int w, bad;
        fr = {2'b01, 2'b01, phy, rg, 2'b10, d};
        start_req(1'b1, phy, {1'b0, rg}, d);
        wait_done(w);
        check(done == 1'b1, "R5 done reached", done, 1);
        check(blog_n == PRE + 34, "R6 period count", blog_n, PRE + 34);
        check_preamble("R2 write preamble");
        bad = 0;
        for (int i = 0; i < 32; i++) if (blog[PRE+i] != {1'b1, fr[31-i]}) bad++;
        check(bad == 0, "R5 frame bits", bad, 0);
        check(blog[PRE+32][1] == 1'b0 && blog[PRE+33][1] == 1'b0, "R6 tail released",
              {blog[PRE+32], blog[PRE+33]}, 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done single write", done, 0);
    endtask

    task automatic t_reject(input logic wr, input logic [RW-1:0] rg, input logic [15:0] exp_rd);
        start_req(wr, 5'd1, rg, 16'h1234);
        check(done == 1'b1, "R8 done next cycle", done, 1);
        check(rd_data == exp_rd, "R8 rejected read data", rd_data, exp_rd);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8 back to idle", {done, busy}, 0);
        repeat (5) @(negedge clk);
        check(blog_n == 0 && mdio_oe == 1'b0, "R8 no bus activity", blog_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read(5'd1, 5'd1, 16'hA5C3, 1'b0);
        t_read(5'h1F, 5'h00, 16'h0001, 1'b0);
        t_write(5'd3, 5'd4, 16'h01E1);
        t_write(5'h15, 5'h1F, 16'hFFFF);
        t_reject(1'b0, 6'd32, 16'hFFFF);
        t_read(5'd2, 5'd5, 16'h8000, 1'b1);
        t_reject(1'b1, 6'd63, 16'h8000);
        check(timing_bad == 0, "R7 mdc timing and data stability", timing_bad, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule